// File: doc/BRIEF.md
# Two-Thread Banked Vector Register File

This block holds the general-purpose vector registers of a processor core that runs two cooperative hardware threads. It has a configurable number of banks (two by default), each with 32 registers of 16 lanes of 32 bits. Each bank has one write port and one read port of its own. When the running program is not marked as threadable, every register in a bank can be reached directly by its index. When the program is threadable, each thread addresses only the lower half of every bank. The upper half holds the registers of the other thread, and a one-bit thread identifier, flipped by a cooperative switch request, selects which half a logical index reaches.

Threads share storage through an address remap and not through duplicated files. The physical index is the logical index with its top bit XORed with the thread identifier. In threaded mode, a logical index in the upper half is an illegal access. It raises a per-bank error flag, the write is dropped, and the read returns zero. Both ports are streams that carry a valid qualifier only. The block accepts a request on every cycle and never applies back-pressure, so no ready signal exists. Read data comes out registered, with a data-valid strobe one cycle after the request.

Top module: `tbrf_regfile`

## Requirements
- R1: While reset is asserted, and directly after it, thread_id is 0 and every bit of rd_data_valid and access_err is 0.
- R2: With threadable at 0, index n (0 to 31) of a bank reaches physical register n. Registers 16 to 31 are distinct from registers 0 to 15, and no access raises access_err.
- R3: With threadable at 1, logical index n (0 to 15) reaches physical register n + 16 * thread_id. Thread 1's copy of register n is therefore physical register n + 16.
- R4: When thread_switch and threadable are both 1 at a rising edge, thread_id toggles and the new value is visible after that edge. When threadable is 0, thread_switch is ignored. Without a switch, thread_id holds.
- R5: A write presented in the same cycle as an accepted switch commits under the thread mapping that was in force before the switch.
- R6: With threadable at 1, a read or write whose logical index has bit 4 set (index 16 or above) sets that bank's access_err bit in the next cycle. Such a write leaves every register unchanged, and such a read returns all-zero data.
- R7: rd_data_valid of a bank rises exactly one cycle after rd_valid and is 0 otherwise. A read and a write to the same register in one cycle return the value held before the write.
- R8: Banks are independent. A write to an index in one bank does not change the same index in another bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| threadable | input | 1 | Current program is threadable; enables the split mapping |
| thread_switch | input | 1 | Cooperative thread-switch request |
| wr_valid | input | NUM_BANKS | Write request per bank |
| wr_addr | input | NUM_BANKS*AW | Logical write index per bank, bank b at [b*AW +: AW] |
| wr_data | input | NUM_BANKS*VEC_W | Write vector per bank, lane i at bits [i*32 +: 32] |
| rd_valid | input | NUM_BANKS | Read request per bank |
| rd_addr | input | NUM_BANKS*AW | Logical read index per bank |
| rd_data | output | NUM_BANKS*VEC_W | Registered read vector per bank |
| rd_data_valid | output | NUM_BANKS | Read data valid, one cycle after rd_valid |
| access_err | output | NUM_BANKS | Illegal threaded access seen in the previous cycle |
| thread_id | output | 1 | Active thread |

## Verification
The hardest condition to observe is where a threaded write physically landed, because a thread can never name the other half of a bank. The stimulus writes in one thread, switches, and writes the same logical index again. It then drops threadable to 0 and reads physical registers 0 to 31 directly. This exposes the remap, confirms that a write coinciding with a switch went to the old thread's half, and shows that an illegal write left its would-be target untouched.

// File: rtl/tbrf_pkg.sv
package tbrf_pkg;
  typedef enum logic {
    THR_LO = 1'b0,
    THR_HI = 1'b1
  } thread_e;

  typedef struct packed {
    logic req;
    logic bad;
  } acc_t;
endpackage

// File: rtl/tbrf_thread_ctrl.sv
module tbrf_thread_ctrl
  import tbrf_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    threadable,
  input  logic    switch_req,
  output thread_e tid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tid <= THR_LO;
    end else if (threadable && switch_req) begin
      tid <= (tid == THR_LO) ? THR_HI : THR_LO;
    end
  end
endmodule

// File: rtl/tbrf_addr_map.sv
module tbrf_addr_map
  import tbrf_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          threadable,
  input  thread_e       tid,
  input  logic [AW-1:0] logical,
  output logic [AW-1:0] physical,
  output logic          illegal
);
  logic [AW-1:0] flip;

  always_comb begin
    flip     = '0;
    flip[AW-1] = logic'(tid);
    illegal  = threadable && logical[AW-1];
    physical = threadable ? (logical ^ flip) : logical;
  end
endmodule

// File: rtl/tbrf_bank.sv
module tbrf_bank
  import tbrf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int VEC_W    = 512,
  parameter int AW       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             threadable,
  input  thread_e          tid,
  input  logic             wr_valid,
  input  logic [AW-1:0]    wr_addr,
  input  logic [VEC_W-1:0] wr_data,
  input  logic             rd_valid,
  input  logic [AW-1:0]    rd_addr,
  output logic [VEC_W-1:0] rd_data,
  output logic             rd_data_valid,
  output logic             access_err
);
  logic [VEC_W-1:0] store [NUM_REGS];
  logic [AW-1:0]    w_phys, r_phys;
  acc_t             w_acc, r_acc;

  tbrf_addr_map #(.AW(AW)) u_wmap (
    .threadable(threadable),
    .tid       (tid),
    .logical   (wr_addr),
    .physical  (w_phys),
    .illegal   (w_acc.bad)
  );

  tbrf_addr_map #(.AW(AW)) u_rmap (
    .threadable(threadable),
    .tid       (tid),
    .logical   (rd_addr),
    .physical  (r_phys),
    .illegal   (r_acc.bad)
  );

  assign w_acc.req = wr_valid;
  assign r_acc.req = rd_valid;

  // Storage carries no reset; only committed, legal writes land.
  always_ff @(posedge clk) begin
    if (w_acc.req && !w_acc.bad) begin
      store[w_phys] <= wr_data;
    end
  end

  // Registered read; sees contents from before this cycle's write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data       <= '0;
      rd_data_valid <= 1'b0;
      access_err    <= 1'b0;
    end else begin
      rd_data_valid <= r_acc.req;
      access_err    <= (r_acc.req && r_acc.bad) || (w_acc.req && w_acc.bad);
      if (r_acc.req) begin
        rd_data <= r_acc.bad ? '0 : store[r_phys];
      end
    end
  end
endmodule

// File: rtl/tbrf_regfile.sv
module tbrf_regfile
  import tbrf_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int NUM_REGS  = 32,
  parameter int LANES     = 16,
  parameter int LANE_W    = 32,
  localparam int VEC_W    = LANES * LANE_W,
  localparam int AW       = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       threadable,
  input  logic                       thread_switch,
  input  logic [NUM_BANKS-1:0]       wr_valid,
  input  logic [NUM_BANKS*AW-1:0]    wr_addr,
  input  logic [NUM_BANKS*VEC_W-1:0] wr_data,
  input  logic [NUM_BANKS-1:0]       rd_valid,
  input  logic [NUM_BANKS*AW-1:0]    rd_addr,
  output logic [NUM_BANKS*VEC_W-1:0] rd_data,
  output logic [NUM_BANKS-1:0]       rd_data_valid,
  output logic [NUM_BANKS-1:0]       access_err,
  output logic                       thread_id
);
  thread_e tid;

  tbrf_thread_ctrl u_thr (
    .clk       (clk),
    .rst_n     (rst_n),
    .threadable(threadable),
    .switch_req(thread_switch),
    .tid       (tid)
  );

  assign thread_id = logic'(tid);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    tbrf_bank #(
      .NUM_REGS(NUM_REGS),
      .VEC_W   (VEC_W),
      .AW      (AW)
    ) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .threadable   (threadable),
      .tid          (tid),
      .wr_valid     (wr_valid[b]),
      .wr_addr      (wr_addr[b*AW +: AW]),
      .wr_data      (wr_data[b*VEC_W +: VEC_W]),
      .rd_valid     (rd_valid[b]),
      .rd_addr      (rd_addr[b*AW +: AW]),
      .rd_data      (rd_data[b*VEC_W +: VEC_W]),
      .rd_data_valid(rd_data_valid[b]),
      .access_err   (access_err[b])
    );
  end
endmodule

// File: rtl/tbrf_regfile_chk.sv
module tbrf_regfile_chk #(
  parameter int NUM_BANKS = 2,
  parameter int VEC_W     = 512,
  parameter int AW        = 5
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       threadable,
  input logic                       thread_switch,
  input logic [NUM_BANKS-1:0]       wr_valid,
  input logic [NUM_BANKS*AW-1:0]    wr_addr,
  input logic [NUM_BANKS-1:0]       rd_valid,
  input logic [NUM_BANKS*AW-1:0]    rd_addr,
  input logic [NUM_BANKS*VEC_W-1:0] rd_data,
  input logic [NUM_BANKS-1:0]       rd_data_valid,
  input logic [NUM_BANKS-1:0]       access_err,
  input logic                       thread_id
);
  p_switch_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (thread_switch && threadable) |=> (thread_id != $past(thread_id)));

  p_switch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(thread_switch && threadable) |=> $stable(thread_id));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    p_illegal_read_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid[b] && threadable && rd_addr[b*AW + AW - 1]) |=> access_err[b]);

    p_illegal_write_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid[b] && threadable && wr_addr[b*AW + AW - 1]) |=> access_err[b]);

    p_illegal_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid[b] && threadable && rd_addr[b*AW + AW - 1]) |=> (rd_data[b*VEC_W +: VEC_W] == '0));

    p_flat_no_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !threadable |=> !access_err[b]);

    p_read_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid[b] |=> rd_data_valid[b]);

    p_no_spurious_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid[b] |=> !rd_data_valid[b]);
  end
endmodule

bind tbrf_regfile tbrf_regfile_chk #(
  .NUM_BANKS(NUM_BANKS),
  .VEC_W    (VEC_W),
  .AW       (AW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .threadable   (threadable),
  .thread_switch(thread_switch),
  .wr_valid     (wr_valid),
  .wr_addr      (wr_addr),
  .rd_valid     (rd_valid),
  .rd_addr      (rd_addr),
  .rd_data      (rd_data),
  .rd_data_valid(rd_data_valid),
  .access_err   (access_err),
  .thread_id    (thread_id)
);

// File: tb/tbrf_regfile_bench.sv
module tbrf_regfile_bench;
  localparam int NB    = 2;
  localparam int AW    = 5;
  localparam int VEC_W = 512;

  logic clk = 1'b0;
  logic rst_n;
  logic threadable, thread_switch;
  logic [NB-1:0]       wr_valid, rd_valid;
  logic [NB*AW-1:0]    wr_addr, rd_addr;
  logic [NB*VEC_W-1:0] wr_data;
  logic [NB*VEC_W-1:0] rd_data;
  logic [NB-1:0]       rd_data_valid, access_err;
  logic                thread_id;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  tbrf_regfile u_tbrf_regfile (
    .clk(clk), .rst_n(rst_n), .threadable(threadable), .thread_switch(thread_switch),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_data_valid(rd_data_valid), .access_err(access_err), .thread_id(thread_id)
  );

  typedef struct packed {
    logic        thr;
    logic        sw;
    logic        wen;
    logic [4:0]  waddr;
    logic [15:0] wseed;
    logic        ren;
    logic [4:0]  raddr;
    logic        chk;
    logic        ezero;
    logic [15:0] eseed;
    logic        eerr;
    logic        etid;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  // Bank 0 only. Fields: thr sw wen waddr wseed ren raddr chk ezero eseed eerr etid req
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,1'b1,5'd3, 16'h0003,1'b0,5'd0, 1'b0,1'b0,16'h0000,1'b0,1'b0,4'd2}, // R2 flat write low
    '{1'b0,1'b0,1'b1,5'd20,16'h0014,1'b1,5'd3, 1'b1,1'b0,16'h0003,1'b0,1'b0,4'd2}, // R2 flat write high, read low
    '{1'b0,1'b0,1'b0,5'd0, 16'h0000,1'b1,5'd20,1'b1,1'b0,16'h0014,1'b0,1'b0,4'd2}, // R2 reg 20 distinct
    '{1'b1,1'b0,1'b1,5'd5, 16'h0105,1'b0,5'd0, 1'b0,1'b0,16'h0000,1'b0,1'b0,4'd3}, // R3 thread 0 write
    '{1'b1,1'b1,1'b1,5'd6, 16'h0106,1'b0,5'd0, 1'b0,1'b0,16'h0000,1'b0,1'b1,4'd5}, // R5 write with switch
    '{1'b1,1'b0,1'b1,5'd5, 16'h1105,1'b0,5'd0, 1'b0,1'b0,16'h0000,1'b0,1'b1,4'd3}, // R3 thread 1 write
    '{1'b1,1'b0,1'b0,5'd0, 16'h0000,1'b1,5'd5, 1'b1,1'b0,16'h1105,1'b0,1'b1,4'd3}, // R3 thread 1 read
    '{1'b1,1'b1,1'b0,5'd0, 16'h0000,1'b1,5'd5, 1'b1,1'b0,16'h1105,1'b0,1'b0,4'd4}, // R4 switch back, read old map
    '{1'b1,1'b0,1'b0,5'd0, 16'h0000,1'b1,5'd5, 1'b1,1'b0,16'h0105,1'b0,1'b0,4'd3}, // R3 thread 0 copy intact
    '{1'b1,1'b0,1'b0,5'd0, 16'h0000,1'b1,5'd6, 1'b1,1'b0,16'h0106,1'b0,1'b0,4'd5}, // R5 landed in thread 0
    '{1'b0,1'b0,1'b0,5'd0, 16'h0000,1'b1,5'd21,1'b1,1'b0,16'h1105,1'b0,1'b0,4'd3}, // R3 phys 21
    '{1'b0,1'b0,1'b0,5'd0, 16'h0000,1'b1,5'd6, 1'b1,1'b0,16'h0106,1'b0,1'b0,4'd5}, // R5 phys 6
    '{1'b1,1'b0,1'b1,5'd20,16'h0BAD,1'b0,5'd0, 1'b0,1'b0,16'h0000,1'b1,1'b0,4'd6}, // R6 illegal write
    '{1'b1,1'b0,1'b0,5'd0, 16'h0000,1'b1,5'd20,1'b1,1'b1,16'h0000,1'b1,1'b0,4'd6}, // R6 illegal read zero
    '{1'b0,1'b0,1'b0,5'd0, 16'h0000,1'b1,5'd20,1'b1,1'b0,16'h0014,1'b0,1'b0,4'd6}, // R6 write suppressed
    '{1'b0,1'b1,1'b0,5'd0, 16'h0000,1'b0,5'd0, 1'b0,1'b0,16'h0000,1'b0,1'b0,4'd4}, // R4 switch ignored flat
    '{1'b0,1'b0,1'b1,5'd3, 16'h0333,1'b1,5'd3, 1'b1,1'b0,16'h0003,1'b0,1'b0,4'd7}, // R7 read-during-write old
    '{1'b0,1'b0,1'b0,5'd0, 16'h0000,1'b1,5'd3, 1'b1,1'b0,16'h0333,1'b0,1'b0,4'd7}  // R7 new value
  };

  function automatic logic [VEC_W-1:0] mkvec(input logic [15:0] seed);
    logic [VEC_W-1:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = {seed, 16'(i)};
    return v;
  endfunction

  task automatic check(input string tag, input logic [VEC_W-1:0] act, input logic [VEC_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    thread_switch = 1'b0;
    wr_valid = '0; rd_valid = '0;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    threadable = 1'b0;
    idle();
    repeat (3) @(posedge clk);
    #1;
    check("R1 tid in reset", VEC_W'(thread_id), '0);
    check("R1 rd_data_valid in reset", VEC_W'(rd_data_valid), '0);
    check("R1 access_err in reset", VEC_W'(access_err), '0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      idle();
      threadable       = TBL[k].thr;
      thread_switch    = TBL[k].sw;
      wr_valid[0]      = TBL[k].wen;
      wr_addr[0 +: AW] = TBL[k].waddr;
      wr_data[0 +: VEC_W] = mkvec(TBL[k].wseed);
      rd_valid[0]      = TBL[k].ren;
      rd_addr[0 +: AW] = TBL[k].raddr;
      @(posedge clk);
      #1;
      check($sformatf("R%0d row %0d tid", TBL[k].req, k), VEC_W'(thread_id), VEC_W'(TBL[k].etid));
      check($sformatf("R%0d row %0d err", TBL[k].req, k), VEC_W'(access_err[0]), VEC_W'(TBL[k].eerr));
      check($sformatf("R%0d row %0d valid", TBL[k].req, k), VEC_W'(rd_data_valid[0]), VEC_W'(TBL[k].ren));
      if (TBL[k].chk)
        check($sformatf("R%0d row %0d data", TBL[k].req, k), rd_data[0 +: VEC_W],
              TBL[k].ezero ? '0 : mkvec(TBL[k].eseed));
      @(negedge clk);
    end

    // R8: bank 1 write to index 3 leaves bank 0 index 3 alone
    idle();
    threadable = 1'b0;
    wr_valid[1] = 1'b1; wr_addr[AW +: AW] = 5'd3; wr_data[VEC_W +: VEC_W] = mkvec(16'h7777);
    @(negedge clk);
    idle();
    rd_valid = 2'b11; rd_addr[0 +: AW] = 5'd3; rd_addr[AW +: AW] = 5'd3;
    @(posedge clk);
    #1;
    check("R8 bank0 unchanged", rd_data[0 +: VEC_W], mkvec(16'h0333));
    check("R8 bank1 written", rd_data[VEC_W +: VEC_W], mkvec(16'h7777));
    check("R8 bank1 no err", VEC_W'(access_err[1]), '0);
    @(negedge clk);

    // R1: reset mid-run returns the thread to 0
    idle();
    threadable = 1'b1; thread_switch = 1'b1;
    @(posedge clk);
    #1;
    check("R4 switch to thread 1", VEC_W'(thread_id), VEC_W'(1));
    @(negedge clk);
    idle();
    rd_valid[0] = 1'b1; rd_addr[0 +: AW] = 5'd18;
    @(posedge clk);
    #1;
    check("R6 illegal read thread 1 err", VEC_W'(access_err[0]), VEC_W'(1));
    @(negedge clk);
    rst_n = 1'b0;
    idle();
    #1;
    check("R1 async reset tid", VEC_W'(thread_id), '0);
    check("R1 async reset err", VEC_W'(access_err), '0);
    check("R1 async reset valid", VEC_W'(rd_data_valid), '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule